// File: doc/BRIEF.md
# Memory Latency Inquiry Responder

This block answers one question per query: can a given address be loaded, or stored to, with low latency right now? It performs no access. It asks the first-level tag lookup first and answers at once on a usable hit. Otherwise it asks the second-level directory and answers when the directory replies. The answer is a 4-bit condition code made of an availability flag, a 2-bit latency class and an overflow flag. When the second-level directory holds a usable copy, the block also asks for that line to be promoted into the first level.

Queries use a valid/ready handshake, and only one query is in flight at a time. A store-type query counts a line as usable only when it is held with exclusive ownership. A shared copy still needs invalidations, so it is reported as unavailable. Wherever the answer is uncertain, the block reports the slower and less available result.

The controller walks five named states:
- `ST_IDLE` moves to `ST_L1_CHK` on an accepted query.
- `ST_L1_CHK` moves to `ST_RESPOND` on a usable first-level hit, and to `ST_DIR_ISSUE` otherwise.
- `ST_DIR_ISSUE` always moves to `ST_DIR_WAIT`.
- `ST_DIR_WAIT` stays put until the directory reply, then moves to `ST_RESPOND`.
- `ST_RESPOND` always returns to `ST_IDLE`.

Top module: `lat_inquiry_resp`

## Requirements
- R1: `q_ready` is high only while idle. A query is taken on a clock edge where `q_valid` and `q_ready` are both high. While busy, `q_valid` and `q_addr` are ignored, and every address the block drives for the query in flight stays equal to the address that was accepted.
- R2: In the cycle after acceptance, `l1_req` is high and `l1_addr` carries the query address. `l1_hit` and `l1_excl` are sampled in that cycle.
- R3: A first-level hit that is usable produces `rsp_valid` in the next cycle with available=1 and latency 00. Usable means a load query, or a store query with `l1_excl`=1. No directory request and no promotion are issued for it.
- R4: Otherwise, `dir_req` pulses for one cycle with `dir_addr` equal to the query address, in the cycle after the first-level check. The response appears in the cycle after `dir_rsp_valid` is sampled high.
- R5: A usable directory hit gives available=1 and latency 01, with `pf_valid` high and `pf_addr` equal to the query address in the response cycle. Usable means a load, or a store with `dir_excl`=1.
- R6: A store query that finds only a shared copy, at either level, reports available=0 and raises no promotion.
- R7: A directory result that is not usable reports available=0. The latency is 10 when `dir_l3_hit`=1, and 11 (main memory) otherwise. `pf_valid` stays low.
- R8: The overflow bit of every response equals `ids_none` in the response cycle.
- R9: `rsp_valid` is a one-cycle pulse, and `q_ready` is high in the following cycle. A response never shows available=1 together with latency bit 1 set.
- R10: Condition code layout: `rsp_cc[3]` is available, `rsp_cc[2:1]` is the latency class and `rsp_cc[0]` is overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Query offered |
| q_ready | output | 1 | Block idle, query can be taken |
| q_addr | input | ADDR_W | Query address |
| q_is_store | input | 1 | 1 = store-type query, 0 = load-type |
| ids_none | input | 1 | No transaction identifiers free |
| l1_req | output | 1 | First-level tag lookup strobe |
| l1_addr | output | ADDR_W | First-level lookup address |
| l1_hit | input | 1 | First-level hit, valid while `l1_req` is high |
| l1_excl | input | 1 | First-level copy held exclusive |
| dir_req | output | 1 | Second-level directory lookup strobe |
| dir_addr | output | ADDR_W | Directory lookup address |
| dir_rsp_valid | input | 1 | Directory result valid |
| dir_hit | input | 1 | Second-level hit |
| dir_excl | input | 1 | Second-level copy held exclusive |
| dir_l3_hit | input | 1 | Line found in third level (else main memory) |
| rsp_valid | output | 1 | Condition code valid |
| rsp_cc | output | 4 | {available, latency[1:0], overflow} |
| pf_valid | output | 1 | Promote line into first level |
| pf_addr | output | ADDR_W | Address of line to promote |

## Verification
The assertions assume three things about the surroundings. The directory asserts `dir_rsp_valid` only while the block waits for it, and only once per request. The first-level result is meaningful only in the cycle of `l1_req`. `ids_none` may change at any time, since it is passed straight through.

The stimulus sweeps all 128 combinations of query type, the two hit flags, the two ownership flags, the third-level hint and `ids_none`. Directory delays vary between cases. Every directory reply is driven strictly inside the waiting window, and some cases keep offering a different query while the block is busy.

// File: rtl/lmi_pkg.sv
package lmi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_CHK,
        ST_DIR_ISSUE,
        ST_DIR_WAIT,
        ST_RESPOND
    } lmi_state_e;

    localparam logic [1:0] LAT_NEAR = 2'b00;
    localparam logic [1:0] LAT_MID  = 2'b01;
    localparam logic [1:0] LAT_FAR  = 2'b10;
    localparam logic [1:0] LAT_MEM  = 2'b11;

    localparam int CC_W = 4;

endpackage

// File: rtl/lmi_fsm.sv
module lmi_fsm
    import lmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_valid,
    input  logic l1_ok,
    input  logic dir_rsp_valid,
    output logic q_ready,
    output logic accept,
    output logic l1_req,
    output logic dir_req,
    output logic rsp_valid,
    output logic load_l1,
    output logic load_dir
);

    lmi_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (q_valid)       state_d = ST_L1_CHK;
            ST_L1_CHK:    state_d = l1_ok ? ST_RESPOND : ST_DIR_ISSUE;
            ST_DIR_ISSUE: state_d = ST_DIR_WAIT;
            ST_DIR_WAIT:  if (dir_rsp_valid) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        q_ready   = (state_q == ST_IDLE);
        accept    = q_ready && q_valid;
        l1_req    = (state_q == ST_L1_CHK);
        load_l1   = l1_req && l1_ok;
        dir_req   = (state_q == ST_DIR_ISSUE);
        load_dir  = (state_q == ST_DIR_WAIT) && dir_rsp_valid;
        rsp_valid = (state_q == ST_RESPOND);
    end

    // R2
    l1_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> l1_req);

    // R4
    dir_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_req |=> !dir_req);

    // R9
    rsp_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (q_ready && !rsp_valid));

endmodule

// File: rtl/lmi_classify.sv
module lmi_classify
    import lmi_pkg::*;
(
    input  logic       is_store,
    input  logic       l1_hit,
    input  logic       l1_excl,
    input  logic       dir_hit,
    input  logic       dir_excl,
    input  logic       dir_l3_hit,
    output logic       l1_ok,
    output logic       dir_avail,
    output logic [1:0] dir_lat,
    output logic       dir_promote
);

    logic dir_usable;

    always_comb begin
        l1_ok       = l1_hit && (!is_store || l1_excl);
        dir_usable  = dir_hit && (!is_store || dir_excl);
        dir_avail   = dir_usable;
        dir_promote = dir_usable;
        if (dir_usable)      dir_lat = LAT_MID;
        else if (dir_l3_hit) dir_lat = LAT_FAR;
        else                 dir_lat = LAT_MEM;
    end

endmodule

// File: rtl/lmi_result.sv
module lmi_result
    import lmi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_l1,
    input  logic       load_dir,
    input  logic       dir_avail,
    input  logic [1:0] dir_lat,
    input  logic       dir_promote,
    output logic       avail,
    output logic [1:0] lat,
    output logic       promote
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail   <= 1'b0;
            lat     <= LAT_MEM;
            promote <= 1'b0;
        end else if (load_l1) begin
            avail   <= 1'b1;
            lat     <= LAT_NEAR;
            promote <= 1'b0;
        end else if (load_dir) begin
            avail   <= dir_avail;
            lat     <= dir_lat;
            promote <= dir_promote;
        end
    end

endmodule

// File: rtl/lat_inquiry_resp.sv
module lat_inquiry_resp
    import lmi_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    output logic              q_ready,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic              q_is_store,
    input  logic              ids_none,
    output logic              l1_req,
    output logic [ADDR_W-1:0] l1_addr,
    input  logic              l1_hit,
    input  logic              l1_excl,
    output logic              dir_req,
    output logic [ADDR_W-1:0] dir_addr,
    input  logic              dir_rsp_valid,
    input  logic              dir_hit,
    input  logic              dir_excl,
    input  logic              dir_l3_hit,
    output logic              rsp_valid,
    output logic [CC_W-1:0]   rsp_cc,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    logic              accept, load_l1, load_dir;
    logic              l1_ok, dir_avail, dir_promote;
    logic [1:0]        dir_lat;
    logic              avail_q, promote_q;
    logic [1:0]        lat_q;
    logic [ADDR_W-1:0] addr_q;
    logic              store_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            store_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= q_addr;
            store_q <= q_is_store;
        end
    end

    lmi_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_valid       (q_valid),
        .l1_ok         (l1_ok),
        .dir_rsp_valid (dir_rsp_valid),
        .q_ready       (q_ready),
        .accept        (accept),
        .l1_req        (l1_req),
        .dir_req       (dir_req),
        .rsp_valid     (rsp_valid),
        .load_l1       (load_l1),
        .load_dir      (load_dir)
    );

    lmi_classify u_cls (
        .is_store    (store_q),
        .l1_hit      (l1_hit),
        .l1_excl     (l1_excl),
        .dir_hit     (dir_hit),
        .dir_excl    (dir_excl),
        .dir_l3_hit  (dir_l3_hit),
        .l1_ok       (l1_ok),
        .dir_avail   (dir_avail),
        .dir_lat     (dir_lat),
        .dir_promote (dir_promote)
    );

    lmi_result u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_l1     (load_l1),
        .load_dir    (load_dir),
        .dir_avail   (dir_avail),
        .dir_lat     (dir_lat),
        .dir_promote (dir_promote),
        .avail       (avail_q),
        .lat         (lat_q),
        .promote     (promote_q)
    );

    always_comb begin
        l1_addr  = addr_q;
        dir_addr = addr_q;
        pf_addr  = addr_q;
        rsp_cc   = {avail_q, lat_q, ids_none};
        pf_valid = rsp_valid && promote_q;
    end

    // R1
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !q_ready) |=> $stable(addr_q));

    // R5
    promote_only_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (rsp_valid && rsp_cc[3:1] == {1'b1, LAT_MID}));

    // R8
    ovf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_cc[0] == ids_none));

    // R9
    avail_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cc[3]) |-> !rsp_cc[2]);

endmodule

// File: tb/tb_lat_inquiry_resp.sv
module tb_lat_inquiry_resp;

    localparam int  ADDR_W  = 40;
    localparam time CLK_PER = 10ns;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              q_valid, q_is_store, ids_none;
    logic              q_ready;
    logic [ADDR_W-1:0] q_addr, l1_addr, dir_addr, pf_addr;
    logic              l1_req, l1_hit, l1_excl;
    logic              dir_req, dir_rsp_valid, dir_hit, dir_excl, dir_l3_hit;
    logic              rsp_valid, pf_valid;
    logic [3:0]        rsp_cc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    lat_inquiry_resp #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready),
        .q_addr(q_addr), .q_is_store(q_is_store), .ids_none(ids_none),
        .l1_req(l1_req), .l1_addr(l1_addr), .l1_hit(l1_hit), .l1_excl(l1_excl),
        .dir_req(dir_req), .dir_addr(dir_addr), .dir_rsp_valid(dir_rsp_valid),
        .dir_hit(dir_hit), .dir_excl(dir_excl), .dir_l3_hit(dir_l3_hit),
        .rsp_valid(rsp_valid), .rsp_cc(rsp_cc), .pf_valid(pf_valid),
        .pf_addr(pf_addr)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input int n);
        bit st, l1h, l1x, dh, dx, l3, ids, poke, l1ok, dok;
        int dly;
        logic [ADDR_W-1:0] a;
        logic [3:0] exp_cc;
        st = n[0]; l1h = n[1]; l1x = n[2]; dh = n[3];
        dx = n[4]; l3 = n[5]; ids = n[6];
        poke = n[0] ^ n[3];
        dly  = (n >> 1) % 4;
        a    = 40'h12_3400_0000 + ADDR_W'(n * 64);
        l1ok = l1h && (!st || l1x);
        dok  = dh && (!st || dx);
        if (l1ok)     exp_cc = {1'b1, 2'b00, ids};
        else if (dok) exp_cc = {1'b1, 2'b01, ids};
        else          exp_cc = {1'b0, (l3 ? 2'b10 : 2'b11), ids};

        @(negedge clk);
        chk(q_ready == 1'b1, "R1 ready when idle", q_ready, 1);
        q_valid = 1'b1; q_addr = a; q_is_store = st; ids_none = ids;
        @(negedge clk);
        chk(l1_req == 1'b1, "R2 l1_req", l1_req, 1);
        chk(l1_addr == a, "R2 l1_addr", l1_addr, a);
        chk(q_ready == 1'b0, "R1 busy", q_ready, 0);
        if (poke) begin q_valid = 1'b1; q_addr = ~a; q_is_store = ~st; end
        else q_valid = 1'b0;
        l1_hit = l1h; l1_excl = l1x;
        @(negedge clk);
        l1_hit = 1'b0; l1_excl = 1'b0;
        if (!l1ok) begin
            chk(rsp_valid == 1'b0, "R4 no early rsp", rsp_valid, 0);
            chk(dir_req == 1'b1, "R4 dir_req", dir_req, 1);
            chk(dir_addr == a, "R1 R4 dir_addr", dir_addr, a);
            @(negedge clk);
            for (int i = 0; i < dly; i++) begin
                chk(rsp_valid == 1'b0 && dir_req == 1'b0, "R4 waiting",
                    {rsp_valid, dir_req}, 0);
                @(negedge clk);
            end
            dir_rsp_valid = 1'b1; dir_hit = dh; dir_excl = dx; dir_l3_hit = l3;
            @(negedge clk);
            dir_rsp_valid = 1'b0; dir_hit = 1'b0; dir_excl = 1'b0; dir_l3_hit = 1'b0;
        end else begin
            chk(dir_req == 1'b0, "R3 no dir_req", dir_req, 0);
        end
        chk(rsp_valid == 1'b1, "R3 R4 rsp_valid", rsp_valid, 1);
        // R10 field layout; R6 R7 unusable cases
        chk(rsp_cc == exp_cc, l1ok ? "R3 cc" : (dok ? "R5 cc" : "R6 R7 cc"),
            rsp_cc, exp_cc);
        chk(rsp_cc[0] == ids, "R8 overflow", rsp_cc[0], ids);
        chk(pf_valid == (!l1ok && dok), "R5 R6 R7 pf_valid", pf_valid, !l1ok && dok);
        if (pf_valid) chk(pf_addr == a, "R5 R1 pf_addr", pf_addr, a);
        q_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && q_ready == 1'b1, "R9 single pulse",
            {rsp_valid, q_ready}, 2'b01);
    endtask

    initial begin
        rst_n = 1'b0; q_valid = 1'b0; q_addr = '0; q_is_store = 1'b0;
        ids_none = 1'b0; l1_hit = 1'b0; l1_excl = 1'b0; dir_rsp_valid = 1'b0;
        dir_hit = 1'b0; dir_excl = 1'b0; dir_l3_hit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(q_ready == 1'b1 && rsp_valid == 1'b0 && pf_valid == 1'b0 &&
            l1_req == 1'b0 && dir_req == 1'b0, "R1 R9 reset state",
            {q_ready, rsp_valid, pf_valid, l1_req, dir_req}, 5'b10000);
        for (int n = 0; n < 128; n++) run_case(n);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule